// File: doc/BRIEF.md
# Branch, Link and Instruction-Set Exchange Unit

This unit resolves the control-flow effect of a 16-bit branch instruction in one clock. Each cycle that `in_valid` is high, it takes the halfword opcode, the address of that halfword, the current link-register contents, the contents of the register named by a register-branch opcode and the NZCV flags. One cycle later it presents the address to fetch next, a link-register write strobe with its data, and the instruction-set state bit: 1 means the 16-bit set and 0 means the 32-bit set. Fetch, pipeline and register file belong to the caller. The caller writes `lr_data` back whenever `lr_we` is high and feeds the updated value on `lr_in` afterwards.

A far call is made of two consecutive halfwords. The prefix halfword parks the high part of the target in the link register. The suffix halfword adds its low part to that register and then overwrites the link register with the return address. Bit 0 of that return address is set, which marks a return into the 16-bit set. The register forms take the new state from bit 0 of the register. The exchange suffix always switches to the 32-bit set and aligns its target to a word boundary.

In the rules below, A is `pc_in`, the address of the halfword. The architectural PC reads as A+4. Offsets are two's-complement and count halfwords.

Top module: `brlx_unit`

## Requirements
- R1: While `rst` is high, and after it is released until the first valid opcode, `out_valid`=0, `lr_we`=0, `next_pc`=0, `lr_data`=0 and `isa16_out`=1.
- R2: An opcode sampled with `in_valid`=1 gives its result with `out_valid`=1 on the next cycle. A cycle with `in_valid`=0 gives `out_valid`=0 and `lr_we`=0 on the next cycle, whatever the opcode.
- R3: Opcode bits [15:12]=1101 with condition field [11:8] from 0000 to 1101 is a conditional branch. When the condition holds, `next_pc` = A+4+sext(bits[7:0])·2, `lr_we`=0 and `isa16_out`=1.
- R4: The condition codes are 0 EQ Z, 1 NE !Z, 2 CS C, 3 CC !C, 4 MI N, 5 PL !N, 6 VS V, 7 VC !V, 8 HI C&!Z, 9 LS !C|Z, 10 GE N==V, 11 LT N!=V, 12 GT !Z&(N==V) and 13 LE Z|(N!=V). The flags input is `nzcv`[3:0] = {N,Z,C,V}. A conditional branch whose condition fails gives `next_pc`=A+2.
- R5: Condition field 1110 or 1111 in the conditional-branch slot, and every opcode outside R3, R6 to R11, gives `next_pc`=A+2, `lr_we`=0 and `isa16_out`=1.
- R6: Bits [15:11]=11100 is an unconditional branch: `next_pc` = A+4+sext(bits[10:0])·2.
- R7: Bits [15:11]=11110 is the far-call prefix. It gives `lr_we`=1, `lr_data` = A+4+sext(bits[10:0])·4096, `next_pc`=A+2 and `isa16_out`=1.
- R8: Bits [15:11]=11111 is the far-call suffix. It gives `next_pc` = `lr_in`+bits[10:0]·2, `lr_we`=1, `lr_data` = (A+2)|1 and `isa16_out`=1.
- R9: Bits [15:11]=11101 is the exchange suffix. It gives `next_pc` = (`lr_in`+bits[10:0]·2) with bits [1:0] cleared, `lr_we`=1, `lr_data`=(A+2)|1 and `isa16_out`=0.
- R10: Bits [15:7]=010001110 is the register branch-exchange. It gives `next_pc` = `rm_data` with bit 0 cleared, `isa16_out` = `rm_data`[0] and `lr_we`=0.
- R11: Bits [15:7]=010001111 is the register branch-link-exchange. It behaves as R10 and also gives `lr_we`=1 and `lr_data`=(A+2)|1.
- R12: A suffix (R8, R9) uses whatever `lr_in` holds, whether or not a prefix came just before it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Opcode and operands are valid this cycle |
| instr | input | 16 | Halfword opcode |
| pc_in | input | ADDR_W | Address of the halfword |
| lr_in | input | ADDR_W | Current link-register value |
| rm_data | input | ADDR_W | Register read for the register-branch forms |
| nzcv | input | 4 | Flags {N,Z,C,V} |
| out_valid | output | 1 | Registered result is valid |
| next_pc | output | ADDR_W | Next fetch address |
| lr_we | output | 1 | Link-register write strobe |
| lr_data | output | ADDR_W | Link-register write data |
| isa16_out | output | 1 | New instruction-set state (1 = 16-bit set) |

## Verification
The assertions assume that the caller holds `lr_in`, `pc_in` and `rm_data` stable for the whole cycle in which the opcode is sampled. They also assume that `rst` is applied before the first valid opcode. The suffix and far-call checks compare the output against the operands of the previous cycle, so they rely on the caller presenting the link value as it stands at issue. The stimulus meets this by changing inputs only on falling edges. It also chains the model's own link-register writes back into `lr_in`, which keeps prefix/suffix pairs coherent. Orphan suffixes and arbitrary register values are also applied.

// File: rtl/brlx_pkg.sv
package brlx_pkg;

  typedef enum logic [2:0] {
    K_NONE,
    K_BCOND,
    K_B,
    K_LINK_PRE,
    K_LINK_T,
    K_LINK_A,
    K_REG_X,
    K_REG_LX
  } br_kind_e;

  localparam int unsigned N_COND = 16;

  // 16-bit class prefixes
  localparam logic [3:0] PFX_BCOND  = 4'b1101;
  localparam logic [4:0] PFX_B      = 5'b11100;
  localparam logic [4:0] PFX_LINK_A = 5'b11101;
  localparam logic [4:0] PFX_PRE    = 5'b11110;
  localparam logic [4:0] PFX_LINK_T = 5'b11111;
  localparam logic [8:0] PFX_REG_X  = 9'b010001110;
  localparam logic [8:0] PFX_REG_LX = 9'b010001111;

endpackage

// File: rtl/brlx_decode.sv
module brlx_decode
  import brlx_pkg::*;
(
  input  logic [8:0] op_hi,   // opcode bits [15:7]
  output br_kind_e   kind
);
  logic [3:0] top4;
  logic [4:0] top5;
  logic [3:0] cfield;

  assign top4   = op_hi[8:5];
  assign top5   = op_hi[8:4];
  assign cfield = op_hi[4:1];

  always_comb begin
    kind = K_NONE;
    if (op_hi == PFX_REG_X)
      kind = K_REG_X;
    else if (op_hi == PFX_REG_LX)
      kind = K_REG_LX;
    else if (top4 == PFX_BCOND && cfield[3:1] != 3'b111)
      kind = K_BCOND;
    else if (top5 == PFX_B)
      kind = K_B;
    else if (top5 == PFX_LINK_A)
      kind = K_LINK_A;
    else if (top5 == PFX_PRE)
      kind = K_LINK_PRE;
    else if (top5 == PFX_LINK_T)
      kind = K_LINK_T;
  end
endmodule

// File: rtl/brlx_cond.sv
module brlx_cond
  import brlx_pkg::*;
(
  input  logic [3:0] cond,
  input  logic [3:0] nzcv,
  output logic       pass
);
  logic fn, fz, fc, fv;
  logic [N_COND-1:0] pred;

  assign fn = nzcv[3];
  assign fz = nzcv[2];
  assign fc = nzcv[1];
  assign fv = nzcv[0];

  // Predicates come in complementary pairs: even code true form, odd code inverted.
  logic [N_COND/2-1:0] base;
  assign base[0] = fz;
  assign base[1] = fc;
  assign base[2] = fn;
  assign base[3] = fv;
  assign base[4] = fc & ~fz;
  assign base[5] = (fn == fv);
  assign base[6] = ~fz & (fn == fv);
  assign base[7] = 1'b1;

  for (genvar g = 0; g < N_COND / 2; g++) begin : g_pair
    assign pred[2*g]   = base[g];
    assign pred[2*g+1] = (g == 7) ? 1'b0 : ~base[g];
  end

  assign pass = pred[cond];
endmodule

// File: rtl/brlx_target.sv
module brlx_target
  import brlx_pkg::*;
#(
  parameter int unsigned ADDR_W = 32
) (
  input  br_kind_e          kind,
  input  logic              pass,
  input  logic [10:0]       off,
  input  logic [ADDR_W-1:0] pc,
  input  logic [ADDR_W-1:0] lr,
  input  logic [ADDR_W-1:0] rm,
  output logic [ADDR_W-1:0] nxt,
  output logic              we,
  output logic [ADDR_W-1:0] ldat,
  output logic              isa16
);
  localparam int unsigned HI_SH = 12;

  logic [ADDR_W-1:0] pc_rd, pc_seq, link_ret, off8_x, off11_x, off_hi_x, off_lo_u, lr_sum;
  logic signed [8:0]        s8;
  logic signed [11:0]       s11;
  logic signed [10+HI_SH:0] shi;

  assign s8       = $signed({off[7:0], 1'b0});
  assign s11      = $signed({off, 1'b0});
  assign shi      = $signed({off, {HI_SH{1'b0}}});
  assign off8_x   = ADDR_W'(s8);
  assign off11_x  = ADDR_W'(s11);
  assign off_hi_x = ADDR_W'(shi);
  assign off_lo_u = ADDR_W'({off, 1'b0});

  assign pc_rd    = pc + ADDR_W'(4);
  assign pc_seq   = pc + ADDR_W'(2);
  assign link_ret = {pc_seq[ADDR_W-1:1], 1'b1};
  assign lr_sum   = lr + off_lo_u;

  always_comb begin
    nxt   = pc_seq;
    we    = 1'b0;
    ldat  = link_ret;
    isa16 = 1'b1;
    unique case (kind)
      K_BCOND:    if (pass) nxt = pc_rd + off8_x;
      K_B:        nxt = pc_rd + off11_x;
      K_LINK_PRE: begin
        we   = 1'b1;
        ldat = pc_rd + off_hi_x;
      end
      K_LINK_T:   begin
        nxt = lr_sum;
        we  = 1'b1;
      end
      K_LINK_A:   begin
        nxt   = {lr_sum[ADDR_W-1:2], 2'b00};
        we    = 1'b1;
        isa16 = 1'b0;
      end
      K_REG_X:    begin
        nxt   = {rm[ADDR_W-1:1], 1'b0};
        isa16 = rm[0];
      end
      K_REG_LX:   begin
        nxt   = {rm[ADDR_W-1:1], 1'b0};
        isa16 = rm[0];
        we    = 1'b1;
      end
      default:    ;
    endcase
  end
endmodule

// File: rtl/brlx_unit.sv
module brlx_unit
  import brlx_pkg::*;
#(
  parameter int unsigned ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic [15:0]       instr,
  input  logic [ADDR_W-1:0] pc_in,
  input  logic [ADDR_W-1:0] lr_in,
  input  logic [ADDR_W-1:0] rm_data,
  input  logic [3:0]        nzcv,
  output logic              out_valid,
  output logic [ADDR_W-1:0] next_pc,
  output logic              lr_we,
  output logic [ADDR_W-1:0] lr_data,
  output logic              isa16_out
);
  br_kind_e          kind;
  logic              pass;
  logic [ADDR_W-1:0] c_nxt, c_ldat;
  logic              c_we, c_isa16;

  brlx_decode u_dec (
    .op_hi (instr[15:7]),
    .kind  (kind)
  );

  brlx_cond u_cond (
    .cond (instr[11:8]),
    .nzcv (nzcv),
    .pass (pass)
  );

  brlx_target #(.ADDR_W(ADDR_W)) u_tgt (
    .kind  (kind),
    .pass  (pass),
    .off   (instr[10:0]),
    .pc    (pc_in),
    .lr    (lr_in),
    .rm    (rm_data),
    .nxt   (c_nxt),
    .we    (c_we),
    .ldat  (c_ldat),
    .isa16 (c_isa16)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      lr_we     <= 1'b0;
      next_pc   <= '0;
      lr_data   <= '0;
      isa16_out <= 1'b1;
    end else begin
      out_valid <= in_valid;
      lr_we     <= in_valid & c_we;
      if (in_valid) begin
        next_pc   <= c_nxt;
        lr_data   <= c_ldat;
        isa16_out <= c_isa16;
      end
    end
  end
endmodule

// File: rtl/brlx_chk.sv
module brlx_chk #(
  parameter int unsigned ADDR_W = 32
) (
  input logic              clk,
  input logic              rst,
  input logic              in_valid,
  input logic [15:0]       instr,
  input logic [ADDR_W-1:0] pc_in,
  input logic [ADDR_W-1:0] lr_in,
  input logic [ADDR_W-1:0] rm_data,
  input logic              out_valid,
  input logic [ADDR_W-1:0] next_pc,
  input logic              lr_we,
  input logic [ADDR_W-1:0] lr_data,
  input logic              isa16_out
);
  // R2
  p_idle_quiet_r2: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> (!out_valid && !lr_we));

  // R2
  p_we_needs_valid_r2: assert property (@(posedge clk) disable iff (rst)
    lr_we |-> out_valid);

  // R7
  p_prefix_r7: assert property (@(posedge clk) disable iff (rst)
    (in_valid && instr[15:11] == 5'b11110) |=>
      (lr_we && isa16_out && next_pc == $past(pc_in) + ADDR_W'(2)));

  // R8 / R12
  p_suffix_r8: assert property (@(posedge clk) disable iff (rst)
    (in_valid && instr[15:11] == 5'b11111) |=>
      (lr_we && isa16_out &&
       lr_data == (($past(pc_in) + ADDR_W'(2)) | ADDR_W'(1)) &&
       next_pc == $past(lr_in) + ADDR_W'({$past(instr[10:0]), 1'b0})));

  // R9
  p_xsuffix_r9: assert property (@(posedge clk) disable iff (rst)
    (in_valid && instr[15:11] == 5'b11101) |=>
      (lr_we && !isa16_out && next_pc[1:0] == 2'b00 && lr_data[0]));

  // R10
  p_regx_r10: assert property (@(posedge clk) disable iff (rst)
    (in_valid && instr[15:7] == 9'b010001110) |=>
      (!lr_we && isa16_out == $past(rm_data[0]) &&
       next_pc == {$past(rm_data[ADDR_W-1:1]), 1'b0}));
endmodule

bind brlx_unit brlx_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .in_valid  (in_valid),
  .instr     (instr),
  .pc_in     (pc_in),
  .lr_in     (lr_in),
  .rm_data   (rm_data),
  .out_valid (out_valid),
  .next_pc   (next_pc),
  .lr_we     (lr_we),
  .lr_data   (lr_data),
  .isa16_out (isa16_out)
);

// File: tb/brlx_unit_tb_top.sv
module brlx_unit_tb_top;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst;
  logic        in_valid;
  logic [15:0] instr;
  logic [31:0] pc_in, lr_in, rm_data;
  logic [3:0]  nzcv;
  logic        out_valid, lr_we, isa16_out;
  logic [31:0] next_pc, lr_data;

  int n_vec = 0;
  int n_bad = 0;
  bit done  = 0;
  logic [31:0] lr_reg = 32'h0;   // bench-side link register

  always #(CLK_PERIOD/2) clk = ~clk;

  brlx_unit dut_i (
    .clk(clk), .rst(rst), .in_valid(in_valid), .instr(instr),
    .pc_in(pc_in), .lr_in(lr_in), .rm_data(rm_data), .nzcv(nzcv),
    .out_valid(out_valid), .next_pc(next_pc), .lr_we(lr_we),
    .lr_data(lr_data), .isa16_out(isa16_out)
  );

  function automatic bit cond_ok(input logic [3:0] c, input logic [3:0] f);
    bit n = f[3], z = f[2], cc = f[1], v = f[0];
    case (c)
      4'd0:  return z;
      4'd1:  return !z;
      4'd2:  return cc;
      4'd3:  return !cc;
      4'd4:  return n;
      4'd5:  return !n;
      4'd6:  return v;
      4'd7:  return !v;
      4'd8:  return cc && !z;
      4'd9:  return !cc || z;
      4'd10: return n == v;
      4'd11: return n != v;
      4'd12: return !z && (n == v);
      4'd13: return z || (n != v);
      default: return 0;
    endcase
  endfunction

  function automatic int sx(input int val, input int bits);
    return (val >= (1 << (bits - 1))) ? val - (1 << bits) : val;
  endfunction

  task automatic model(input logic [15:0] op, input logic [31:0] a, lr, rm,
                       input logic [3:0] f, output logic [31:0] np,
                       output bit we, output logic [31:0] ld, output bit t);
    int o11 = int'(op[10:0]);
    np = a + 2; we = 0; ld = 32'h0; t = 1;
    if (op[15:7] == 9'b010001110) begin
      np = rm & ~32'h1; t = rm[0];
    end else if (op[15:7] == 9'b010001111) begin
      np = rm & ~32'h1; t = rm[0]; we = 1; ld = (a + 2) | 1;
    end else if (op[15:12] == 4'b1101) begin
      if (op[11:8] < 4'd14 && cond_ok(op[11:8], f))
        np = a + 4 + 32'(sx(int'(op[7:0]), 8) * 2);
    end else if (op[15:11] == 5'b11100) begin
      np = a + 4 + 32'(sx(o11, 11) * 2);
    end else if (op[15:11] == 5'b11110) begin
      we = 1; ld = a + 4 + 32'(sx(o11, 11) * 4096);
    end else if (op[15:11] == 5'b11111) begin
      np = lr + 32'(o11 * 2); we = 1; ld = (a + 2) | 1;
    end else if (op[15:11] == 5'b11101) begin
      np = (lr + 32'(o11 * 2)) & ~32'h3; we = 1; ld = (a + 2) | 1; t = 0;
    end
  endtask

  task automatic apply(input logic [15:0] op, input logic [31:0] a, rm,
                       input logic [3:0] f, input string req);
    logic [31:0] enp, eld;
    bit ewe, et;
    @(negedge clk);
    in_valid = 1; instr = op; pc_in = a; lr_in = lr_reg; rm_data = rm; nzcv = f;
    model(op, a, lr_reg, rm, f, enp, ewe, eld, et);
    @(posedge clk); #1;
    n_vec++;
    if (out_valid !== 1'b1 || next_pc !== enp || lr_we !== ewe || isa16_out !== et ||
        (ewe && lr_data !== eld)) begin
      n_bad++;
      $display("FAIL %s op=%h: got v=%b pc=%h we=%b ld=%h t=%b, expected v=1 pc=%h we=%b ld=%h t=%b",
               req, op, out_valid, next_pc, lr_we, lr_data, isa16_out, enp, ewe, eld, et);
    end
    if (ewe) lr_reg = eld;
  endtask

  task automatic idle(input logic [15:0] op);
    @(negedge clk);
    in_valid = 0; instr = op;
    @(posedge clk); #1;
    n_vec++;
    if (out_valid !== 1'b0 || lr_we !== 1'b0) begin
      n_bad++;
      $display("FAIL R2 idle: got v=%b we=%b, expected v=0 we=0", out_valid, lr_we);
    end
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: got timeout, expected completion");
      $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    rst = 1; in_valid = 0; instr = 0; pc_in = 0; lr_in = 0; rm_data = 0; nzcv = 0;
    repeat (3) @(posedge clk);
    #1;
    n_vec++;
    if (out_valid !== 0 || lr_we !== 0 || next_pc !== 0 || lr_data !== 0 || isa16_out !== 1) begin
      n_bad++;
      $display("FAIL R1 reset: got v=%b we=%b pc=%h ld=%h t=%b, expected 0 0 0 0 1",
               out_valid, lr_we, next_pc, lr_data, isa16_out);
    end
    @(negedge clk); rst = 0;

    // R2: idle cycles ignore a link prefix on the opcode bus
    idle(16'hF123);
    idle(16'h4780);

    // R3 / R4: every condition code with several flag patterns, forward and backward
    for (int c = 0; c < 14; c++)
      for (int fl = 0; fl < 16; fl += 5) begin
        apply({4'b1101, 4'(c), 8'h12}, 32'h0000_1000, 0, 4'(fl), "R3/R4");
        apply({4'b1101, 4'(c), 8'hF0}, 32'h0000_2000, 0, 4'(fl), "R4 backward");
      end
    // R5: reserved condition fields and unrelated opcodes
    apply(16'hDE55, 32'h0000_3000, 0, 4'hF, "R5 field 1110");
    apply(16'hDFAB, 32'h0000_3002, 0, 4'h0, "R5 field 1111");
    apply(16'h1C08, 32'h0000_3004, 0, 4'h4, "R5 non-branch");
    // R6
    apply(16'hE3FF, 32'h0001_0000, 0, 0, "R6 forward");
    apply(16'hE400, 32'h0001_0000, 0, 0, "R6 backward");
    // R7 + R8: far call pairs
    apply(16'hF001, 32'h0002_0000, 0, 0, "R7 prefix fwd");
    apply(16'hF802, 32'h0002_0002, 0, 0, "R8 suffix");
    apply(16'hF7FF, 32'h0008_0000, 0, 0, "R7 prefix back");
    apply(16'hFFFE, 32'h0008_0002, 0, 0, "R8 suffix back");
    // R9: exchange pair
    apply(16'hF000, 32'h0004_0000, 0, 0, "R7 prefix");
    apply(16'hE803, 32'h0004_0002, 0, 0, "R9 exchange");
    // R12: orphan suffixes with an arbitrary link value
    lr_reg = 32'h1234_5677;
    apply(16'hF810, 32'h0005_0000, 0, 0, "R12 orphan");
    lr_reg = 32'hABCD_0001;
    apply(16'hE811, 32'h0005_0010, 0, 0, "R12 orphan x");
    // R10 / R11
    apply(16'h4770, 32'h0006_0000, 32'h0000_8001, 0, "R10 odd");
    apply(16'h4708, 32'h0006_0000, 32'h0000_8000, 0, "R10 even");
    apply(16'h47C8, 32'h0006_0010, 32'h0000_9001, 0, "R11 to16");
    apply(16'h47F0, 32'h0006_0020, 32'h0000_A004, 0, "R11 to32");

    // Mixed random stream with the bench link register chained back
    for (int i = 0; i < 400; i++) begin
      logic [15:0] op;
      logic [31:0] a = {$urandom} & 32'h00FF_FFFE;
      case ($urandom % 8)
        0: op = {4'b1101, 12'($urandom)};
        1: op = {5'b11100, 11'($urandom)};
        2: op = {5'b11110, 11'($urandom)};
        3: op = {5'b11111, 11'($urandom)};
        4: op = {5'b11101, 11'($urandom)};
        5: op = {9'b010001110, 4'($urandom), 3'b000};
        6: op = {9'b010001111, 4'($urandom), 3'b000};
        default: op = 16'($urandom);
      endcase
      apply(op, a, $urandom, 4'($urandom), "R3-mix");
      if (i % 50 == 0) idle(op);
    end

    done = 1;
    $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule